// File: doc/BRIEF.md
# Timed Multi-Channel Start Synchroniser

This unit sits on the local register bus of a compute tile. It compares a free-running global cycle count against a programmed 64-bit reference cycle. Each of its transporter channels carries a signed offset from that reference. When the global count reaches the reference plus a channel's offset, that channel gets a single-cycle start pulse. One pulse is allowed per arming, and committing a new reference arms every channel again.

The unit also has a blocking wait register. A processor that reads it is held off by the bus handshake until the global count reaches the reference cycle, so software can line itself up with the same instant the transporters use. The reference is written in two 32-bit halves. The low half is staged, and the whole value takes effect when the high half is written.

Top module: `start_sync`

## Requirements
- R1: After reset, start_o is all zero, every channel is disarmed, the reference and all offsets read as zero, and req_ready is high.
- R2: A write to 0x0010_0000 stages the low half of the reference only. A write to 0x0010_0004 commits {written data, staged low half} as the 64-bit reference. Reads of 0x0010_0000 and 0x0010_0004 return the low and high halves of the committed reference.
- R3: Channel i's 32-bit offset lives at 0x0010_0100 + 4*i, for i from 0 to NUM_CH-1. A read of that address returns the stored value.
- R4: Channel i drives start_o[i] high for exactly one cycle: the cycle after the one in which time_i equals (reference + sign-extended offset[i]) modulo 2^64, provided the channel is armed. The sum carries across the 32-bit boundary.
- R5: A channel fires at most once per arming. A commit of the reference (high-half write) arms all channels. An offset write does not arm a channel.
- R6: A read of 0x0010_0200 holds req_ready low while time_i < reference (unsigned). Once time_i >= reference, the read is accepted and returns 1. With a past reference, it is accepted at once.
- R7: An accepted read gives rsp_valid high for one cycle, on the cycle after the handshake, with its data on rsp_rdata. Writes are always accepted at once and give no response.
- R8: Reads of unmapped addresses return zero. Writes to unmapped addresses change no register.
- R9: Negative offsets fire before the reference cycle, at the cycle given by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Global free-running cycle count |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| start_o | output | NUM_CH | Per-channel start pulses |

## Verification
The bench builds the block with its default of 16 channels, so it can reach the last offset slot and the first unmapped word just above the window. The bench also drives time_i itself and can jump it. This lets it place a reference whose channel targets straddle a 32-bit carry, and a reference already in the past. A behavioural model checks the pulse vector and the wait-register handshake against the design on every cycle.

// File: rtl/start_sync_pkg.sv
package start_sync_pkg;

    localparam int SYNC_DW = 32;
    localparam int SYNC_TW = 2 * SYNC_DW;

    localparam logic [31:0] A_REF_LO   = 32'h0010_0000;
    localparam logic [31:0] A_REF_HI   = 32'h0010_0004;
    localparam logic [31:0] A_OFF_BASE = 32'h0010_0100;
    localparam logic [31:0] A_WAIT     = 32'h0010_0200;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_REF_LO,
        RK_REF_HI,
        RK_OFF,
        RK_WAIT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } sync_dec_t;

    function automatic sync_dec_t sync_decode(input logic [31:0] a, input int unsigned nch);
        sync_dec_t   d;
        logic [31:0] lim;
        lim    = A_OFF_BASE + 32'(4 * nch);
        d.kind = RK_NONE;
        d.idx  = '0;
        if (a[31:2] == A_REF_LO[31:2]) begin
            d.kind = RK_REF_LO;
        end else if (a[31:2] == A_REF_HI[31:2]) begin
            d.kind = RK_REF_HI;
        end else if (a[31:2] == A_WAIT[31:2]) begin
            d.kind = RK_WAIT;
        end else if (a >= A_OFF_BASE && a < lim) begin
            d.kind = RK_OFF;
            d.idx  = 8'((a - A_OFF_BASE) >> 2);
        end
        return d;
    endfunction

    function automatic logic [SYNC_TW-1:0] sync_target(input logic [SYNC_TW-1:0] base,
                                                        input logic [SYNC_DW-1:0] off);
        return base + {{(SYNC_TW - SYNC_DW){off[SYNC_DW-1]}}, off};
    endfunction

endpackage

// File: rtl/sync_regs.sv
module sync_regs
    import start_sync_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SYNC_TW-1:0]              time_i,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [31:0]                     req_addr,
    input  logic [SYNC_DW-1:0]              req_wdata,
    output logic                            req_ready,
    output logic                            rsp_valid,
    output logic [SYNC_DW-1:0]              rsp_rdata,
    output logic [SYNC_TW-1:0]              ref_o,
    output logic [NUM_CH-1:0][SYNC_DW-1:0]  off_o,
    output logic                            rearm_o
);

    sync_dec_t                         dec;
    logic                              reached;
    logic                              acc_rd;
    logic                              acc_wr;
    logic [SYNC_DW-1:0]                stage_q;
    logic [SYNC_TW-1:0]                ref_q;
    logic [NUM_CH-1:0][SYNC_DW-1:0]    off_q;
    logic [SYNC_DW-1:0]                rd_mux;

    assign dec       = sync_decode(req_addr, NUM_CH);
    assign reached   = (time_i >= ref_q);
    assign req_ready = !(req_valid && !req_write && dec.kind == RK_WAIT && !reached);
    assign acc_rd    = req_valid && req_ready && !req_write && !rst;
    assign acc_wr    = req_valid && req_write && !rst;
    assign rearm_o   = acc_wr && dec.kind == RK_REF_HI;
    assign ref_o     = ref_q;
    assign off_o     = off_q;

    always_comb begin
        rd_mux = '0;
        unique case (dec.kind)
            RK_REF_LO: rd_mux = ref_q[SYNC_DW-1:0];
            RK_REF_HI: rd_mux = ref_q[SYNC_TW-1:SYNC_DW];
            RK_WAIT:   rd_mux = SYNC_DW'(1);
            RK_OFF: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (dec.idx == 8'(i)) rd_mux = off_q[i];
                end
            end
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            ref_q     <= '0;
            off_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_rd;
            if (acc_rd) rsp_rdata <= rd_mux;
            if (acc_wr && dec.kind == RK_REF_LO) stage_q <= req_wdata;
            if (rearm_o) ref_q <= {req_wdata, stage_q};
            for (int i = 0; i < NUM_CH; i++) begin
                if (acc_wr && dec.kind == RK_OFF && dec.idx == 8'(i)) off_q[i] <= req_wdata;
            end
        end
    end

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid); // R7
    AST_WAIT_RETURNS_ONE: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && dec.kind == RK_WAIT) |=> (rsp_rdata == SYNC_DW'(1))); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && dec.kind == RK_NONE) |=> (rsp_rdata == '0)); // R8
    AST_COMMIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        rearm_o |=> (ref_q[SYNC_TW-1:SYNC_DW] == $past(req_wdata))); // R2

endmodule

// File: rtl/sync_channel.sv
module sync_channel
    import start_sync_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SYNC_TW-1:0] time_i,
    input  logic [SYNC_TW-1:0] ref_i,
    input  logic [SYNC_DW-1:0] off_i,
    input  logic               rearm_i,
    output logic               start_o
);

    logic               armed_q;
    logic [SYNC_TW-1:0] target;
    logic               hit;

    assign target = sync_target(ref_i, off_i);
    assign hit    = armed_q && (time_i == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            start_o <= 1'b0;
        end else begin
            start_o <= hit;
            if (rearm_i)  armed_q <= 1'b1;
            else if (hit) armed_q <= 1'b0;
        end
    end

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (start_o && !$past(rearm_i)) |-> !armed_q); // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (start_o && !$past(rearm_i)) |=> !start_o); // R4

endmodule

// File: rtl/start_sync.sv
module start_sync
    import start_sync_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [63:0]        time_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_CH-1:0]  start_o
);

    logic [SYNC_TW-1:0]             ref_w;
    logic [NUM_CH-1:0][SYNC_DW-1:0] off_w;
    logic                           rearm_w;

    sync_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .time_i    (time_i),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ref_o     (ref_w),
        .off_o     (off_w),
        .rearm_o   (rearm_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sync_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .time_i  (time_i),
            .ref_i   (ref_w),
            .off_i   (off_w[g]),
            .rearm_i (rearm_w),
            .start_o (start_o[g])
        );
    end

endmodule

// File: tb/start_sync_bench.sv
module start_sync_bench;

    localparam int NCH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [63:0]      gtime = 64'd1000;
    logic             jump_req = 1'b0;
    logic [63:0]      jump_val = '0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [31:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic             req_ready;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic [NCH-1:0]   start_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int pcount [NCH];

    always #4 clk = ~clk;

    start_sync #(.NUM_CH(NCH)) u_start_sync (
        .clk(clk), .rst(rst), .time_i(gtime),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .start_o(start_o)
    );

    always @(posedge clk) gtime <= jump_req ? jump_val : gtime + 64'd1;

    // behavioural model
    logic [63:0]    m_ref;
    logic [31:0]    m_stage;
    logic [31:0]    m_off [NCH];
    bit             m_arm [NCH];
    logic [NCH-1:0] exp_start = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ref = '0; m_stage = '0; exp_start = '0;
            for (int i = 0; i < NCH; i++) begin m_off[i] = '0; m_arm[i] = 0; end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                logic [63:0] tgt;
                tgt = m_ref + {{32{m_off[i][31]}}, m_off[i]};
                exp_start[i] = m_arm[i] && (gtime == tgt);
                if (exp_start[i]) m_arm[i] = 0;
            end
            if (req_valid && req_write) begin
                if (req_addr == 32'h0010_0000) m_stage = req_wdata;
                else if (req_addr == 32'h0010_0004) begin
                    m_ref = {req_wdata, m_stage};
                    for (int i = 0; i < NCH; i++) m_arm[i] = 1;
                end else if (req_addr >= 32'h0010_0100 && req_addr < 32'h0010_0100 + 4*NCH)
                    m_off[(req_addr - 32'h0010_0100) >> 2] = req_wdata;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            logic er;
            er = !(req_valid && !req_write && req_addr == 32'h0010_0200 && gtime < m_ref);
            check("R4 start_o per cycle", 64'(start_o), 64'(exp_start));
            check("R6 req_ready per cycle", 64'(req_ready), 64'(er));
            for (int i = 0; i < NCH; i++) if (start_o[i]) pcount[i]++;
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, output int stalls);
        stalls = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        #1;
        while (!req_ready) begin @(negedge clk); #1; stalls++; end
        @(negedge clk);
        req_valid = 0;
        #1;
        check("R7 rsp_valid after read", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
        @(negedge clk);
        #1;
        check("R7 rsp_valid one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic set_ref(input logic [63:0] v);
        wr(32'h0010_0000, v[31:0]);
        wr(32'h0010_0004, v[63:32]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int st;
        logic [63:0] v;
        for (int i = 0; i < NCH; i++) pcount[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 start_o after reset", 64'(start_o), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        rd(32'h0010_0000, d, st); check("R1 ref lo reset", 64'(d), 64'd0);
        rd(32'h0010_0004, d, st); check("R1 ref hi reset", 64'(d), 64'd0);
        rd(32'h0010_010C, d, st); check("R1 offset reset", 64'(d), 64'd0);
        idle(5);
        check("R1 no pulse while disarmed", 64'(pcount[3]), 64'd0);

        // R3 offsets
        wr(32'h0010_0100, 32'd5);
        wr(32'h0010_0104, 32'hFFFF_FFFD);
        wr(32'h0010_011C, 32'h7FFF_FFFF);
        wr(32'h0010_013C, 32'd40);
        rd(32'h0010_0104, d, st); check("R3 offset ch1 readback", 64'(d), 64'hFFFF_FFFD);
        rd(32'h0010_013C, d, st); check("R3 offset ch15 readback", 64'(d), 64'd40);

        // R4 / R9 firing pattern
        v = gtime + 64'd30;
        set_ref(v);
        rd(32'h0010_0000, d, st); check("R2 ref lo readback", 64'(d), 64'(v[31:0]));
        idle(80);
        check("R9 negative offset ch1 fired once", 64'(pcount[1]), 64'd1);
        check("R4 ch0 fired once", 64'(pcount[0]), 64'd1);
        check("R4 ch2 zero offset fired once", 64'(pcount[2]), 64'd1);
        check("R4 ch15 fired once", 64'(pcount[15]), 64'd1);
        check("R4 ch7 far target not fired", 64'(pcount[7]), 64'd0);
        // R5: offset write does not rearm
        wr(32'h0010_010C, 32'd100);
        idle(90);
        check("R5 offset write does not rearm", 64'(pcount[3]), 64'd1);

        // R2: low-only write does not commit
        wr(32'h0010_0000, 32'h1234_5678);
        rd(32'h0010_0000, d, st); check("R2 low write staged only", 64'(d), 64'(v[31:0]));

        // R6 blocking read
        v = gtime + 64'd30;
        set_ref(v);
        rd(32'h0010_0200, d, st);
        check("R6 wait read returns 1", 64'(d), 64'd1);
        check("R6 wait read stalled", 64'(st >= 20), 64'd1);
        idle(130);
        check("R5 rearm fires ch3 again", 64'(pcount[3]), 64'd2);
        // R6 past reference
        set_ref(gtime - 64'd50);
        rd(32'h0010_0200, d, st);
        check("R6 past ref no stall", 64'(st), 64'd0);
        check("R6 past ref returns 1", 64'(d), 64'd1);

        // R8 unmapped
        wr(32'h0010_0140, 32'hDEAD_BEEF);
        wr(32'h0010_0008, 32'hCAFE_0001);
        rd(32'h0010_0140, d, st); check("R8 unmapped above window reads 0", 64'(d), 64'd0);
        rd(32'h0010_0008, d, st); check("R8 unmapped reads 0", 64'(d), 64'd0);
        rd(32'h0010_0100, d, st); check("R8 ch0 unchanged", 64'(d), 64'd5);
        rd(32'h0010_013C, d, st); check("R8 ch15 unchanged", 64'(d), 64'd40);

        // R4 carry across 32-bit boundary
        set_ref(64'h0000_0003_0000_0000);
        @(negedge clk);
        jump_req = 1; jump_val = 64'h0000_0002_FFFF_FFF0;
        @(negedge clk);
        jump_req = 0;
        rd(32'h0010_0004, d, st); check("R2 ref hi commit", 64'(d), 64'd3);
        idle(150);
        check("R4 carry ch1 fired", 64'(pcount[1]), 64'd3);
        check("R4 carry ch15 fired", 64'(pcount[15]), 64'd3);
        idle(5);
        finish_run();
    end

endmodule